// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore and Mailbox Block

This block lets two processor cores share resources without a bus lock. It holds eight one-bit semaphores. Each semaphore takes a full 32-bit word of address space. A read of a semaphore word returns the value the semaphore had before the read and leaves it taken, all in one access. A core acquires a lock by reading until it gets 0, and releases it by writing 0. A status word shows all semaphores at once and has no side effect.

The block also holds two 32-bit mailboxes, each paired with an interrupt control word. Each control word carries an enable and a flag and drives the interrupt line of one core. One core fills a mailbox and raises the flag to signal the other core. The other core reads the data and clears the flag.

Each core reaches the block through its own synchronous register port, with a byte address, read and write strobes and write data. Read data returns one cycle after the read strobe. Both ports may access the block in the same cycle. The block resolves collisions with fixed rules, so the result never depends on timing.

Top module: `xcore_semabox`

## Requirements
- R1: After reset every semaphore is free, both mailboxes are zero, both enables and both flags are zero, both interrupt outputs are low, and read data is zero.
- R2: A read at a semaphore word (byte offset 4*i, i = 0..7) returns the semaphore's previous value in bit 0, with bits 31:1 zero. The semaphore is taken (1) from the next cycle on.
- R3: A write to a semaphore word with bit 0 equal to 0 frees that semaphore. A write with bit 0 equal to 1 leaves it unchanged.
- R4: The word at offset 0x100 returns semaphore i in bit i for i = 0..7 (1 = taken), as held at the start of the access cycle, with all other bits zero. Reading it changes no semaphore.
- R5: When both ports read the same free semaphore in one cycle, port 0 receives 0 and port 1 receives 1, and the semaphore ends up taken.
- R6: When a read and a write reach the same semaphore in one cycle, the read takes effect first. The reader gets the old value, and a write of bit 0 = 0 leaves the semaphore free.
- R7: The control word at 0x40 drives irq_o[0] and the one at 0x48 drives irq_o[1]. Each holds an enable at bit 0 and a flag at bit 16, both set and cleared by the written bit. An interrupt output equals enable AND flag of its word, starting in the cycle after the write.
- R8: The mailbox words at 0x44 and 0x4C each store all 32 written bits and return them on read.
- R9: When both ports write the same control or mailbox word in one cycle, the value from port 1 is stored.
- R10: These read as zero and ignore writes: offsets 0x20–0x3F and 0x50–0xFF, any offset above 0x100, any byte address whose two low bits are not zero, and any bit of a defined word not named above. Such a write changes no semaphore, mailbox or control bit.
- R11: Read data is registered. It presents the read result in the cycle after a read strobe, and is zero in the cycle after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_addr | input | 9 | Byte address from core 0 |
| p0_rd | input | 1 | Read strobe from core 0 |
| p0_wr | input | 1 | Write strobe from core 0 |
| p0_wdata | input | 32 | Write data from core 0 |
| p0_rdata | output | 32 | Registered read data to core 0 |
| p1_addr | input | 9 | Byte address from core 1 |
| p1_rd | input | 1 | Read strobe from core 1 |
| p1_wr | input | 1 | Write strobe from core 1 |
| p1_wdata | input | 32 | Write data from core 1 |
| p1_rdata | output | 32 | Registered read data to core 1 |
| irq_o | output | 2 | Interrupt lines, bit 0 to core 0, bit 1 to core 1 |

## Verification
The hardest situation to reach from the ports is a same-cycle collision on one semaphore. Examples are both ports reading a free semaphore, or one port taking a semaphore while the other releases it. The outcome depends on the ordering rules and is invisible to either core alone. Directed steps build each collision on purpose: they first bring the semaphore to a known state, then drive both ports in one cycle. The status word then shows the final state. A long random phase follows. It draws both ports' addresses from a small pool of semaphore, control, mailbox and reserved offsets, so the ports hit the same word often, and it checks every cycle against the reference model.

// File: rtl/xsb_pkg.sv
package xsb_pkg;

    // Word index of the first interrupt control word (byte offset 0x40).
    localparam int unsigned CH_BASE_WORD = 16;
    // Word index of the status summary word (byte offset 0x100).
    localparam int unsigned STATUS_WORD  = 64;
    // Bit positions inside an interrupt control word.
    localparam int unsigned EN_BIT       = 0;
    localparam int unsigned FLAG_BIT     = 16;

    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_SEM  = 3'd1,
        REG_CTRL = 3'd2,
        REG_BOX  = 3'd3,
        REG_STAT = 3'd4
    } reg_kind_e;

endpackage

// File: rtl/xsb_decode.sv
module xsb_decode
    import xsb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned NUM_SEM = 8,
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] ch_off;

    assign word   = addr[ADDR_W-1:2];
    assign ch_off = word - WORD_W'(CH_BASE_WORD);

    always_comb begin
        kind = REG_NONE;
        idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (32'(word) < NUM_SEM) begin
                kind = REG_SEM;
                idx  = IDX_W'(word);
            end else if ((32'(word) >= CH_BASE_WORD) &&
                         (32'(word) < CH_BASE_WORD + 2 * NUM_CH)) begin
                kind = ch_off[0] ? REG_BOX : REG_CTRL;
                idx  = IDX_W'(ch_off >> 1);
            end else if (32'(word) == STATUS_WORD) begin
                kind = REG_STAT;
            end
        end
    end

endmodule

// File: rtl/xsb_sem_bank.sv
module xsb_sem_bank #(
    parameter int unsigned NUM_SEM = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take0,
    input  logic [IDX_W-1:0]   idx0,
    input  logic               rel0,
    input  logic               take1,
    input  logic [IDX_W-1:0]   idx1,
    input  logic               rel1,
    output logic [NUM_SEM-1:0] sem_q,
    output logic               old0,
    output logic               old1
);
    localparam int unsigned SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [NUM_SEM-1:0] sem;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    logic [NUM_SEM-1:0] nxt_bits;
    logic [SLOTS-1:0]   padded;

    // Per semaphore: reads set first, then a release clears.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        logic hit_set, hit_clr;
        assign hit_set = (take0 && (idx0 == IDX_W'(i))) ||
                         (take1 && (idx1 == IDX_W'(i)));
        assign hit_clr = (rel0 && (idx0 == IDX_W'(i))) ||
                         (rel1 && (idx1 == IDX_W'(i)));
        assign nxt_bits[i] = hit_clr ? 1'b0 : (hit_set | st_q.sem[i]);
    end

    assign padded = SLOTS'(st_q.sem);

    always_comb begin
        st_d     = st_q;
        st_d.sem = nxt_bits;
        // Port 0 is served first; port 1 sees a same-cycle take by port 0.
        old0 = padded[idx0];
        old1 = padded[idx1] | (take0 && (idx0 == idx1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sem_q = st_q.sem;

endmodule

// File: rtl/xsb_channel.sv
module xsb_channel
    import xsb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cwe0,
    input  logic              cwe1,
    input  logic              bwe0,
    input  logic              bwe1,
    input  logic [DATA_W-1:0] wd0,
    input  logic [DATA_W-1:0] wd1,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] box_rd,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic              flag;
        logic [DATA_W-1:0] box;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Port 0 applied first, port 1 last so port 1 wins a tie.
        if (cwe0) begin
            st_d.en   = wd0[EN_BIT];
            st_d.flag = wd0[FLAG_BIT];
        end
        if (cwe1) begin
            st_d.en   = wd1[EN_BIT];
            st_d.flag = wd1[FLAG_BIT];
        end
        if (bwe0) st_d.box = wd0;
        if (bwe1) st_d.box = wd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[EN_BIT]   = st_q.en;
        ctrl_rd[FLAG_BIT] = st_q.flag;
    end

    assign box_rd = st_q.box;
    assign irq    = st_q.en & st_q.flag;

endmodule

// File: rtl/xcore_semabox.sv
module xcore_semabox
    import xsb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SEM = 8,
    parameter int unsigned NUM_CH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_rd,
    input  logic              p0_wr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_rd,
    input  logic              p1_wr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned MAXN      = (NUM_SEM > NUM_CH) ? NUM_SEM : NUM_CH;
    localparam int unsigned IDX_W     = (MAXN > 1) ? $clog2(MAXN) : 1;
    localparam int unsigned SLOTS     = 1 << IDX_W;

    logic [ADDR_W-1:0] addr_a [NUM_PORTS];
    logic              rd_a   [NUM_PORTS];
    logic              wr_a   [NUM_PORTS];
    logic [DATA_W-1:0] wd_a   [NUM_PORTS];
    reg_kind_e         kind_a [NUM_PORTS];
    logic [IDX_W-1:0]  idx_a  [NUM_PORTS];
    logic              take_a [NUM_PORTS];
    logic              rel_a  [NUM_PORTS];
    logic              old_a  [NUM_PORTS];

    assign addr_a[0] = p0_addr;  assign addr_a[1] = p1_addr;
    assign rd_a[0]   = p0_rd;    assign rd_a[1]   = p1_rd;
    assign wr_a[0]   = p0_wr;    assign wr_a[1]   = p1_wr;
    assign wd_a[0]   = p0_wdata; assign wd_a[1]   = p1_wdata;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        xsb_decode #(
            .ADDR_W (ADDR_W),
            .NUM_SEM(NUM_SEM),
            .NUM_CH (NUM_CH),
            .IDX_W  (IDX_W)
        ) u_dec (
            .addr(addr_a[p]),
            .kind(kind_a[p]),
            .idx (idx_a[p])
        );
        assign take_a[p] = rd_a[p] && (kind_a[p] == REG_SEM);
        assign rel_a[p]  = wr_a[p] && (kind_a[p] == REG_SEM) && !wd_a[p][0];
    end

    logic [NUM_SEM-1:0] sem_q;

    xsb_sem_bank #(
        .NUM_SEM(NUM_SEM),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .take0(take_a[0]),
        .idx0 (idx_a[0]),
        .rel0 (rel_a[0]),
        .take1(take_a[1]),
        .idx1 (idx_a[1]),
        .rel1 (rel_a[1]),
        .sem_q(sem_q),
        .old0 (old_a[0]),
        .old1 (old_a[1])
    );

    logic [DATA_W-1:0] ctrl_rd [SLOTS];
    logic [DATA_W-1:0] box_rd  [SLOTS];

    for (genvar c = 0; c < SLOTS; c++) begin : g_ch
        if (c < NUM_CH) begin : g_live
            logic cwe0, cwe1, bwe0, bwe1;
            assign cwe0 = wr_a[0] && (kind_a[0] == REG_CTRL) && (idx_a[0] == IDX_W'(c));
            assign cwe1 = wr_a[1] && (kind_a[1] == REG_CTRL) && (idx_a[1] == IDX_W'(c));
            assign bwe0 = wr_a[0] && (kind_a[0] == REG_BOX)  && (idx_a[0] == IDX_W'(c));
            assign bwe1 = wr_a[1] && (kind_a[1] == REG_BOX)  && (idx_a[1] == IDX_W'(c));
            xsb_channel #(
                .DATA_W(DATA_W)
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .cwe0   (cwe0),
                .cwe1   (cwe1),
                .bwe0   (bwe0),
                .bwe1   (bwe1),
                .wd0    (wd_a[0]),
                .wd1    (wd_a[1]),
                .ctrl_rd(ctrl_rd[c]),
                .box_rd (box_rd[c]),
                .irq    (irq_o[c])
            );
        end else begin : g_pad
            assign ctrl_rd[c] = '0;
            assign box_rd[c]  = '0;
        end
    end

    typedef struct packed {
        logic [NUM_PORTS-1:0][DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            st_d.rdata[p] = '0;
            if (rd_a[p]) begin
                case (kind_a[p])
                    REG_SEM:  st_d.rdata[p] = DATA_W'(old_a[p]);
                    REG_STAT: st_d.rdata[p] = DATA_W'(sem_q);
                    REG_CTRL: st_d.rdata[p] = ctrl_rd[idx_a[p]];
                    REG_BOX:  st_d.rdata[p] = box_rd[idx_a[p]];
                    default:  st_d.rdata[p] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p0_rdata = st_q.rdata[0];
    assign p1_rdata = st_q.rdata[1];

endmodule

// File: rtl/xsb_checker.sv
module xsb_checker
    import xsb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SEM = 8,
    parameter int unsigned NUM_CH  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  p0_addr,
    input logic               p0_rd,
    input logic               p0_wr,
    input logic               p0_wbit0,
    input logic               p0_wbit16,
    input logic [DATA_W-1:0]  p0_rdata,
    input logic [ADDR_W-1:0]  p1_addr,
    input logic               p1_rd,
    input logic               p1_wr,
    input logic               p1_wbit0,
    input logic [DATA_W-1:0]  p1_rdata,
    input logic               irq0,
    input logic [NUM_SEM-1:0] sem
);
    function automatic logic is_sem(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00) && (32'(a[ADDR_W-1:2]) < NUM_SEM);
    endfunction

    function automatic logic is_rsvd(input logic [ADDR_W-1:0] a);
        logic [31:0] w;
        w = 32'(a[ADDR_W-1:2]);
        if (a[1:0] != 2'b00) return 1'b1;
        return !((w < NUM_SEM) ||
                 ((w >= CH_BASE_WORD) && (w < CH_BASE_WORD + 2 * NUM_CH)) ||
                 (w == STATUS_WORD));
    endfunction

    function automatic logic [NUM_SEM-1:0] sem_mask(input logic [ADDR_W-1:0] a);
        return is_sem(a) ? (NUM_SEM'(1) << a[ADDR_W-1:2]) : '0;
    endfunction

    logic [NUM_SEM-1:0] t0, t1, c0, c1;
    logic               ctrl0_hit0, ctrl0_hit1;

    assign t0 = p0_rd ? sem_mask(p0_addr) : '0;
    assign t1 = p1_rd ? sem_mask(p1_addr) : '0;
    assign c0 = (p0_wr && !p0_wbit0) ? sem_mask(p0_addr) : '0;
    assign c1 = (p1_wr && !p1_wbit0) ? sem_mask(p1_addr) : '0;
    assign ctrl0_hit0 = p0_wr && (p0_addr == ADDR_W'(CH_BASE_WORD * 4));
    assign ctrl0_hit1 = p1_wr && (p1_addr == ADDR_W'(CH_BASE_WORD * 4));

    // R2: a read by port 0 with no concurrent release leaves the semaphore taken
    assert_take_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((t0 != '0) && (((c0 | c1) & t0) == '0)) |=> ((sem & $past(t0)) == $past(t0)));

    // R2: port 0 gets the value held before its read
    assert_take_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (t0 != '0) |=> (p0_rdata == DATA_W'($past((sem & t0) != '0))));

    // R3 / R6: a release leaves the semaphore free even against a read
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0 | c1) != '0) |=> ((sem & $past(c0 | c1)) == '0));

    // R5: both ports read the same semaphore, port 1 loses
    assert_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((t0 != '0) && (t1 == t0)) |=> (p1_rdata == DATA_W'(1)));

    // R4 / R10: semaphores nobody took or released stay unchanged
    assert_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((sem ^ $past(sem)) & ~$past(t0 | t1 | c0 | c1)) == '0));

    // R10: reserved and misaligned reads return zero
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd && is_rsvd(p0_addr)) |=> (p0_rdata == '0));

    // R11: no read strobe gives zero read data next cycle
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_rd |=> (p1_rdata == '0));

    // R7: enable and flag written by port 0 alone raise irq 0
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0_hit0 && p0_wbit0 && p0_wbit16 && !ctrl0_hit1) |=> irq0);

endmodule

bind xcore_semabox xsb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SEM(NUM_SEM),
    .NUM_CH (NUM_CH)
) i_xsb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .p0_addr  (p0_addr),
    .p0_rd    (p0_rd),
    .p0_wr    (p0_wr),
    .p0_wbit0 (p0_wdata[0]),
    .p0_wbit16(p0_wdata[16]),
    .p0_rdata (p0_rdata),
    .p1_addr  (p1_addr),
    .p1_rd    (p1_rd),
    .p1_wr    (p1_wr),
    .p1_wbit0 (p1_wdata[0]),
    .p1_rdata (p1_rdata),
    .irq0     (irq_o[0]),
    .sem      (sem_q)
);

// File: tb/test_xcore_semabox.sv
module test_xcore_semabox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  p0_addr = '0, p1_addr = '0;
    logic        p0_rd = 1'b0, p0_wr = 1'b0, p1_rd = 1'b0, p1_wr = 1'b0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic [1:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xcore_semabox i_xcore_semabox (
        .clk(clk), .rst_n(rst_n),
        .p0_addr(p0_addr), .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_addr(p1_addr), .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .irq_o(irq_o)
    );

    // Reference model state
    bit          m_sem [8];
    bit          m_en [2];
    bit          m_flag [2];
    logic [31:0] m_box [2];

    // 0 none, 1 sem, 2 ctrl, 3 box, 4 status
    function automatic int region(input logic [8:0] a);
        int w;
        w = int'(a) / 4;
        if (a[1:0] != 2'b00) return 0;
        if (w < 8) return 1;
        if (w >= 16 && w < 20) return ((w - 16) % 2 == 0) ? 2 : 3;
        if (w == 64) return 4;
        return 0;
    endfunction

    function automatic string tag_of(input logic [8:0] a);
        case (region(a))
            1: return "R2";
            2: return "R7";
            3: return "R8";
            4: return "R4";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] m_peek(input logic [8:0] a);
        int w;
        logic [31:0] v;
        w = int'(a) / 4;
        v = '0;
        case (region(a))
            1: v[0] = m_sem[w];
            2: begin v[0] = m_en[(w - 16) / 2]; v[16] = m_flag[(w - 16) / 2]; end
            3: v = m_box[(w - 16) / 2];
            4: for (int i = 0; i < 8; i++) v[i] = m_sem[i];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic void m_poke(input logic [8:0] a, input logic [31:0] d);
        int w;
        w = int'(a) / 4;
        case (region(a))
            1: if (!d[0]) m_sem[w] = 1'b0;
            2: begin m_en[(w - 16) / 2] = d[0]; m_flag[(w - 16) / 2] = d[16]; end
            3: m_box[(w - 16) / 2] = d;
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, sample at the next negedge.
    task automatic step(input logic [8:0] a0, input bit r0, input bit w0, input logic [31:0] d0,
                        input logic [8:0] a1, input bit r1, input bit w1, input logic [31:0] d1,
                        input string tag);
        logic [31:0] e0, e1, snap1;
        string t0, t1;
        p0_addr = a0; p0_rd = r0; p0_wr = w0; p0_wdata = d0;
        p1_addr = a1; p1_rd = r1; p1_wr = w1; p1_wdata = d1;
        snap1 = m_peek(a1);
        e0 = r0 ? m_peek(a0) : '0;
        if (r0 && region(a0) == 1) m_sem[int'(a0) / 4] = 1'b1;
        if (r1 && region(a1) == 1) begin
            e1 = m_peek(a1);
            m_sem[int'(a1) / 4] = 1'b1;
        end else begin
            e1 = r1 ? snap1 : '0;
        end
        if (w0) m_poke(a0, d0);
        if (w1) m_poke(a1, d1);
        t0 = (tag != "") ? tag : (r0 ? tag_of(a0) : "R11");
        t1 = (tag != "") ? tag : (r1 ? tag_of(a1) : "R11");
        @(posedge clk);
        @(negedge clk);
        check(t0, "p0_rdata", p0_rdata, e0);
        check(t1, "p1_rdata", p1_rdata, e1);
        check((tag != "") ? tag : "R7", "irq_o", 32'(irq_o),
              32'({m_en[1] & m_flag[1], m_en[0] & m_flag[0]}));
    endtask

    task automatic idle(input string tag);
        step(9'h0, 0, 0, '0, 9'h0, 0, 0, '0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    logic [8:0] pool [14];

    initial begin
        for (int i = 0; i < 8; i++) pool[i] = 9'(i * 4);
        pool[8] = 9'h040; pool[9] = 9'h044; pool[10] = 9'h048; pool[11] = 9'h04C;
        pool[12] = 9'h100; pool[13] = 9'h024;
        for (int i = 0; i < 8; i++) m_sem[i] = 0;
        for (int c = 0; c < 2; c++) begin m_en[c] = 0; m_flag[c] = 0; m_box[c] = '0; end

        repeat (4) @(negedge clk);
        check("R1", "p0_rdata in reset", p0_rdata, '0);
        check("R1", "irq_o in reset", 32'(irq_o), '0);
        rst_n = 1'b1;

        // R1: state after reset
        step(9'h100, 1, 0, '0, 9'h044, 1, 0, '0, "R1");
        step(9'h040, 1, 0, '0, 9'h04C, 1, 0, '0, "R1");

        // R2: take sem 2 twice
        step(9'h008, 1, 0, '0, 9'h0, 0, 0, '0, "R2");
        step(9'h008, 1, 0, '0, 9'h0, 0, 0, '0, "R2");
        // R4: status shows sem 2, repeated read has no effect
        step(9'h100, 1, 0, '0, 9'h100, 1, 0, '0, "R4");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R4");
        // R3: writing 1 keeps, writing 0 frees
        step(9'h008, 0, 1, 32'hFFFF_FFFF, 9'h0, 0, 0, '0, "R3");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R3");
        step(9'h008, 0, 1, 32'hFFFF_FFFE, 9'h0, 0, 0, '0, "R3");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R3");
        // R5: both ports read free sem 5
        step(9'h014, 1, 0, '0, 9'h014, 1, 0, '0, "R5");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R5");
        // R6: port 1 reads sem 5 while port 0 releases it
        step(9'h014, 0, 1, '0, 9'h014, 1, 0, '0, "R6");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R6");
        // R6: port 0 reads sem 7 (free) while port 1 releases it
        step(9'h01C, 1, 0, '0, 9'h01C, 0, 1, '0, "R6");
        step(9'h100, 1, 0, '0, 9'h0, 0, 0, '0, "R6");
        // R7: interrupt control
        step(9'h040, 0, 1, 32'h0001_0001, 9'h0, 0, 0, '0, "R7");
        step(9'h040, 0, 1, 32'h0001_0000, 9'h040, 1, 0, '0, "R7");
        step(9'h040, 1, 0, '0, 9'h048, 0, 1, 32'hFFFF_FFFF, "R7");
        step(9'h048, 1, 0, '0, 9'h048, 0, 1, 32'h0000_0001, "R7");
        // R8: mailbox
        step(9'h044, 0, 1, 32'hDEAD_BEEF, 9'h0, 0, 0, '0, "R8");
        step(9'h0, 0, 0, '0, 9'h044, 1, 0, '0, "R8");
        // R9: both write mailbox 1 and control 0
        step(9'h04C, 0, 1, 32'h1111_1111, 9'h04C, 0, 1, 32'h2222_2222, "R9");
        step(9'h04C, 1, 0, '0, 9'h0, 0, 0, '0, "R9");
        step(9'h040, 0, 1, 32'h0000_0000, 9'h040, 0, 1, 32'h0001_0001, "R9");
        step(9'h040, 1, 0, '0, 9'h0, 0, 0, '0, "R9");
        // R10: reserved and misaligned accesses
        step(9'h020, 0, 1, 32'hFFFF_FFFF, 9'h0FC, 0, 1, 32'h0, "R10");
        step(9'h001, 0, 1, 32'h0, 9'h045, 0, 1, 32'h0, "R10");
        step(9'h020, 1, 0, '0, 9'h104, 1, 0, '0, "R10");
        step(9'h002, 1, 0, '0, 9'h050, 1, 0, '0, "R10");
        step(9'h100, 1, 0, '0, 9'h044, 1, 0, '0, "R10");
        // R11: data returns zero after a cycle with no read
        step(9'h044, 1, 0, '0, 9'h0, 0, 0, '0, "R11");
        idle("R11");

        // Random phase across both ports
        for (int n = 0; n < 3000; n++) begin
            logic [8:0] a0, a1;
            logic [31:0] d0, d1;
            bit r0, w0, r1, w1;
            a0 = pool[$urandom % 14];
            a1 = pool[$urandom % 14];
            r0 = ($urandom % 3) == 0; w0 = ($urandom % 3) == 0;
            r1 = ($urandom % 3) == 0; w1 = ($urandom % 3) == 0;
            d0 = $urandom; d1 = $urandom;
            step(a0, r0, w0, d0, a1, r1, w1, d1, "");
        end
        idle("R11");
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule